// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block issues one free-form command to a serial flash over a single data line. A command is one opcode byte plus zero to eight payload bytes. The payload comes from a 64-bit transmit word. While each payload byte goes out on the output data line, the byte arriving on the input data line is captured into the matching position of a 64-bit receive word. The other two flash lines are held at levels chosen when the command starts, for example to keep write-protect and hold inactive.

Two optional steps can run before the command. The first polls the flash status register until its busy bit clears. The second sends a single write-enable byte. Each step uses its own chip-select period. When the command frame ends, the block raises a one-cycle completion pulse and drops its busy flag.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, csN is 1, sck is 0, busy and ready are 0, both receive words are zero, and io2 and io3 are 1.
- R2: The command frame carries the opcode and then the payload bytes in ascending index order. Each byte goes out MSB first on io0. The frame holds exactly lenCode bytes in total, so lenCode = 1 sends only the opcode.
- R3: Payload byte k (0..7) is taken from bits [8k+7:8k] of {txHigh, txLow}. Bytes 0..3 come from txLow and bytes 4..7 from txHigh.
- R4: The byte received during payload slot k replaces bits [8k+7:8k] of {rxHigh, rxLow}. Positions beyond the frame keep the transmit value captured at start. The byte received during the opcode is dropped.
- R5: A lenCode of 0 acts as 1, and a lenCode above 9 acts as 9.
- R6: io2 and io3 hold the io2Level and io3Level values captured at start for the whole time csN is low.
- R7: When wrenFirst is set, a one-byte frame with opcode 0x06 runs before the command frame, in its own chip-select period.
- R8: When waitIdle is set, two-byte frames with opcode 0x05 run first. The polling repeats while bit 0 of the second received byte is 1.
- R9: csN stays low for a whole frame, and sck is low whenever csN is high. Data changes on falling sck and is sampled on rising sck. Between frames, csN stays high for at least CS_GAP cycles.
- R10: busy is 1 in the cycle after start is accepted. ready pulses for exactly one cycle, one clock after csN rises at the end of the command frame, and busy is 0 in that same cycle.
- R11: A start pulse while busy is ignored. The running sequence, its opcode, its length and its data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted when idle |
| opcode | input | 8 | Command opcode |
| lenCode | input | 4 | Total frame length in bytes (1..9) |
| wrenFirst | input | 1 | Send write-enable before the command |
| waitIdle | input | 1 | Poll the status register until not busy |
| io2Level | input | 1 | Level held on io2 |
| io3Level | input | 1 | Level held on io3 |
| txLow | input | 32 | Payload bytes 0..3 |
| txHigh | input | 32 | Payload bytes 4..7 |
| rxLow | output | 32 | Received bytes 0..3 |
| rxHigh | output | 32 | Received bytes 4..7 |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | One-cycle completion pulse |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| io0 | output | 1 | Serial data out |
| io1 | input | 1 | Serial data in |
| io2 | output | 1 | Static line 2 |
| io3 | output | 1 | Static line 3 |

## Verification
The assertions check the following on every cycle:
- sck stays quiet while csN is high.
- io2 and io3 hold steady inside a frame.
- The clamped length stays in range.
- ready is a single-cycle pulse, follows the rise of csN by exactly one clock, and never coincides with busy.

Only the bench scenarios can show the content of the frames. That covers the frame order (status polls, then write-enable, then the command), the byte order and bit order on the line, the mapping of received bytes into the receive words, the clamping of out-of-range lengths, and that a start pulse while busy is ignored.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DATA_BYTES = 8;
  localparam int MAX_FRAME  = DATA_BYTES + 1;
  localparam int LEN_W      = 4;

  typedef enum logic [1:0] {
    FK_STATUS = 2'd0,
    FK_WREN   = 2'd1,
    FK_MAIN   = 2'd2
  } frameKind_t;

  typedef struct packed {
    logic       latch;
    logic       frameGo;
    frameKind_t kind;
  } ctlStrobe_t;
endpackage

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int         HALF_DIV  = 2,
  parameter logic [7:0] WREN_OP   = 8'h06,
  parameter logic [7:0] STATUS_OP = 8'h05,
  parameter int         WIP_BIT   = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            ctl,
  input  logic [7:0]            opcode,
  input  logic [LEN_W-1:0]      lenCode,
  input  logic                  io2Level,
  input  logic                  io3Level,
  input  logic [31:0]           txLow,
  input  logic [31:0]           txHigh,
  input  logic                  io1,
  output logic                  sck,
  output logic                  csN,
  output logic                  io0,
  output logic                  io2Out,
  output logic                  io3Out,
  output logic [31:0]           rxLow,
  output logic [31:0]           rxHigh,
  output logic                  frameDone,
  output logic                  statusWip
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam int WORD_W = 8 * DATA_BYTES;

  logic [7:0]        opQ;
  logic [LEN_W-1:0]  lenQ;
  logic [WORD_W-1:0] txQ;
  logic [WORD_W-1:0] rxQ;
  logic              io2Q, io3Q;
  frameKind_t        kindQ;
  logic              active;
  logic              sckQ, csNQ, doneQ, wipQ;
  logic [7:0]        txSh, rxSh;
  logic [2:0]        bitIdx;
  logic [LEN_W-1:0]  byteIdx;
  logic [DIV_W-1:0]  divCnt;

  logic [LEN_W-1:0]  lenEff;
  logic [LEN_W-1:0]  frameLen;
  logic [7:0]        firstByte;
  logic [7:0]        nextByte;

  // Length clamp: 0 acts as 1, anything above the frame limit acts as the limit.
  always_comb begin
    if (lenCode == '0)                        lenEff = LEN_W'(1);
    else if (lenCode > LEN_W'(MAX_FRAME))     lenEff = LEN_W'(MAX_FRAME);
    else                                      lenEff = lenCode;
  end

  always_comb begin
    case (kindQ)
      FK_STATUS: frameLen = LEN_W'(2);
      FK_WREN:   frameLen = LEN_W'(1);
      default:   frameLen = lenQ;
    endcase
  end

  always_comb begin
    case (ctl.kind)
      FK_STATUS: firstByte = STATUS_OP;
      FK_WREN:   firstByte = WREN_OP;
      default:   firstByte = opQ;
    endcase
  end

  // Payload slot k is sent as frame byte k+1; byteIdx is the current frame byte.
  always_comb begin
    nextByte = 8'h00;
    if (kindQ == FK_MAIN) begin
      for (int b = 0; b < DATA_BYTES; b++) begin
        if (byteIdx == LEN_W'(b)) nextByte = txQ[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ     <= '0;
      lenQ    <= LEN_W'(1);
      txQ     <= '0;
      rxQ     <= '0;
      io2Q    <= 1'b1;
      io3Q    <= 1'b1;
      kindQ   <= FK_MAIN;
      active  <= 1'b0;
      sckQ    <= 1'b0;
      csNQ    <= 1'b1;
      doneQ   <= 1'b0;
      wipQ    <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
      bitIdx  <= '0;
      byteIdx <= '0;
      divCnt  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (ctl.latch) begin
        opQ  <= opcode;
        lenQ <= lenEff;
        txQ  <= {txHigh, txLow};
        rxQ  <= {txHigh, txLow};
        io2Q <= io2Level;
        io3Q <= io3Level;
        wipQ <= 1'b0;
      end
      if (ctl.frameGo) begin
        active  <= 1'b1;
        csNQ    <= 1'b0;
        sckQ    <= 1'b0;
        kindQ   <= ctl.kind;
        txSh    <= firstByte;
        bitIdx  <= '0;
        byteIdx <= '0;
        divCnt  <= '0;
      end else if (active) begin
        if (divCnt != DIV_LAST) begin
          divCnt <= divCnt + 1'b1;
        end else begin
          divCnt <= '0;
          if (!sckQ) begin
            sckQ <= 1'b1;
            rxSh <= {rxSh[6:0], io1};
          end else begin
            sckQ <= 1'b0;
            if (bitIdx == 3'd7) begin
              bitIdx <= '0;
              if (kindQ == FK_MAIN) begin
                for (int b = 0; b < DATA_BYTES; b++) begin
                  if (byteIdx == LEN_W'(b + 1)) rxQ[b*8 +: 8] <= rxSh;
                end
              end
              if (kindQ == FK_STATUS && byteIdx == LEN_W'(1)) wipQ <= rxSh[WIP_BIT];
              if (byteIdx == frameLen - LEN_W'(1)) begin
                active <= 1'b0;
                csNQ   <= 1'b1;
                doneQ  <= 1'b1;
              end else begin
                byteIdx <= byteIdx + LEN_W'(1);
                txSh    <= nextByte;
              end
            end else begin
              bitIdx <= bitIdx + 3'd1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assign sck       = sckQ;
  assign csN       = csNQ;
  assign io0       = active ? txSh[7] : 1'b0;
  assign io2Out    = io2Q;
  assign io3Out    = io3Q;
  assign rxLow     = rxQ[31:0];
  assign rxHigh    = rxQ[WORD_W-1:32];
  assign frameDone = doneQ;
  assign statusWip = wipQ;

  p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  p_lvl_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> ($stable(io2Out) && $stable(io3Out)));

  p_len_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lenQ >= LEN_W'(1)) && (lenQ <= LEN_W'(MAX_FRAME)));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int CS_GAP = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wrenFirst,
  input  logic       waitIdle,
  input  logic       frameDone,
  input  logic       statusWip,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       ready
);
  localparam int GAP_W = $clog2(CS_GAP + 1) > 0 ? $clog2(CS_GAP + 1) : 1;

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_RUN} state_t;

  state_t      state;
  frameKind_t  pend;
  logic [GAP_W-1:0] gapCnt;
  logic        wrenQ, readyQ, busyQ;

  always_comb begin
    ctl.latch   = (state == S_IDLE) && start;
    ctl.frameGo = (state == S_GAP) && (gapCnt == '0);
    ctl.kind    = pend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      pend   <= FK_MAIN;
      gapCnt <= '0;
      wrenQ  <= 1'b0;
      readyQ <= 1'b0;
      busyQ  <= 1'b0;
    end else begin
      readyQ <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          busyQ  <= 1'b1;
          wrenQ  <= wrenFirst;
          pend   <= waitIdle ? FK_STATUS : (wrenFirst ? FK_WREN : FK_MAIN);
          gapCnt <= '0;
          state  <= S_GAP;
        end
        S_GAP: begin
          if (gapCnt == '0) state <= S_RUN;
          else              gapCnt <= gapCnt - 1'b1;
        end
        S_RUN: if (frameDone) begin
          gapCnt <= GAP_W'(CS_GAP);
          case (pend)
            FK_STATUS: begin
              pend  <= statusWip ? FK_STATUS : (wrenQ ? FK_WREN : FK_MAIN);
              state <= S_GAP;
            end
            FK_WREN: begin
              pend  <= FK_MAIN;
              state <= S_GAP;
            end
            default: begin
              readyQ <= 1'b1;
              busyQ  <= 1'b0;
              state  <= S_IDLE;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy  = busyQ;
  assign ready = readyQ;

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);

  p_ready_not_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !busy);
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CS_GAP   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [3:0]  lenCode,
  input  logic        wrenFirst,
  input  logic        waitIdle,
  input  logic        io2Level,
  input  logic        io3Level,
  input  logic [31:0] txLow,
  input  logic [31:0] txHigh,
  output logic [31:0] rxLow,
  output logic [31:0] rxHigh,
  output logic        busy,
  output logic        ready,
  output logic        sck,
  output logic        csN,
  output logic        io0,
  input  logic        io1,
  output logic        io2,
  output logic        io3
);
  ctlStrobe_t ctl;
  logic       frameDone;
  logic       statusWip;

  flash_cmd_ctrl #(.CS_GAP(CS_GAP)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .wrenFirst (wrenFirst),
    .waitIdle  (waitIdle),
    .frameDone (frameDone),
    .statusWip (statusWip),
    .ctl       (ctl),
    .busy      (busy),
    .ready     (ready)
  );

  flash_cmd_dp #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .opcode    (opcode),
    .lenCode   (lenCode),
    .io2Level  (io2Level),
    .io3Level  (io3Level),
    .txLow     (txLow),
    .txHigh    (txHigh),
    .io1       (io1),
    .sck       (sck),
    .csN       (csN),
    .io0       (io0),
    .io2Out    (io2),
    .io3Out    (io3),
    .rxLow     (rxLow),
    .rxHigh    (rxHigh),
    .frameDone (frameDone),
    .statusWip (statusWip)
  );

  p_ready_after_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> ($past(csN) && !$past(csN, 2)));
endmodule

// File: tb/flash_cmd_engine_bench.sv
module flash_cmd_engine_bench;
  localparam int CS_GAP = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [3:0]  lenCode = 4'd1;
  logic        wrenFirst = 1'b0;
  logic        waitIdle = 1'b0;
  logic        io2Level = 1'b0;
  logic        io3Level = 1'b0;
  logic [31:0] txLow = '0;
  logic [31:0] txHigh = '0;
  logic [31:0] rxLow, rxHigh;
  logic        busy, ready, sck, csN, io0, io2, io3;
  logic        io1 = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_engine #(.HALF_DIV(2), .CS_GAP(CS_GAP)) u_flash_cmd_engine (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .lenCode(lenCode),
    .wrenFirst(wrenFirst), .waitIdle(waitIdle), .io2Level(io2Level), .io3Level(io3Level),
    .txLow(txLow), .txHigh(txHigh), .rxLow(rxLow), .rxHigh(rxHigh), .busy(busy),
    .ready(ready), .sck(sck), .csN(csN), .io0(io0), .io1(io1), .io2(io2), .io3(io3)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mainResp(input logic [7:0] op, input int b);
    return 8'h3C ^ 8'(b * 27) ^ op;
  endfunction

  // ---------------- flash model ----------------
  logic [7:0] fb [16][10];
  int   flen [16];
  int   nFrames = 0;
  int   wipLeft = 0;
  int   partialErr = 0;
  int   bitsIn = 0;
  int   bitsOut = 0;
  logic [7:0] curIn = 8'h00;
  logic [7:0] curOp = 8'h00;
  logic sckP = 1'b0;
  logic csP = 1'b1;

  function automatic logic [7:0] respByte(input int b);
    if (b == 0) return 8'h00;
    if (curOp == 8'h05) return 8'hA4 | {7'b0, (wipLeft > 0)};
    return mainResp(curOp, b);
  endfunction

  always @(sck or csN) begin
    logic [7:0] rb;
    int idx;
    if (sck !== sckP && !$isunknown(sck)) begin
      if (sck === 1'b1) begin
        curIn = {curIn[6:0], io0};
        bitsIn++;
        if (bitsIn % 8 == 0) begin
          idx = bitsIn / 8 - 1;
          if (nFrames < 16 && idx < 10) fb[nFrames][idx] = curIn;
          if (idx == 0) curOp = curIn;
        end
      end else begin
        bitsOut++;
        rb = respByte(bitsOut / 8);
        io1 = rb[7 - (bitsOut % 8)];
      end
      sckP = sck;
    end
    if (csN !== csP && !$isunknown(csN)) begin
      if (csN === 1'b0) begin
        bitsIn = 0;
        bitsOut = 0;
        io1 = 1'b0;
      end else begin
        if (nFrames < 16) flen[nFrames] = bitsIn / 8;
        if (bitsIn % 8 != 0) partialErr++;
        if (curOp == 8'h05 && wipLeft > 0) wipLeft--;
        nFrames++;
      end
      csP = csN;
    end
  end

  // ---------------- cycle monitor ----------------
  int cyc = 0;
  int lastRise = 0;
  int gapErr = 0, sckErr = 0, ioErr = 0, readyErr = 0, readyCnt = 0;
  logic csPrevClk = 1'b1;
  logic expIo2 = 1'b1, expIo3 = 1'b1;
  bit timedOut = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (csN && !csPrevClk) lastRise = cyc;
      if (!csN && csPrevClk && lastRise > 0 && (cyc - lastRise) < CS_GAP) gapErr++;
      if (csN && sck) sckErr++;
      if (!csN && (io2 !== expIo2 || io3 !== expIo3)) ioErr++;
      if (ready) begin
        readyCnt++;
        if (!(lastRise == cyc - 1 && !busy)) readyErr++;
      end
      csPrevClk = csN;
      if (cyc >= 150000) timedOut = 1'b1;
    end
  end

  // ---------------- transaction ----------------
  task automatic runTxn(input logic [7:0] op, input int len, input logic [63:0] tx,
                        input bit wr, input bit wt, input int wip,
                        input bit l2, input bit l3, input bit dup);
    int eff, nPoll, expFrames, rc, g0, s0, i0, r0, p0, mainIdx;
    bit dataOk;
    logic [63:0] expRx;
    eff = (len == 0) ? 1 : (len > 9 ? 9 : len);
    nPoll = wt ? wip + 1 : 0;
    expFrames = nPoll + (wr ? 1 : 0) + 1;
    @(negedge clk);
    nFrames = 0;
    wipLeft = wt ? wip : 0;
    g0 = gapErr; s0 = sckErr; i0 = ioErr; r0 = readyErr; p0 = partialErr;
    opcode = op; lenCode = 4'(len); wrenFirst = wr; waitIdle = wt;
    io2Level = l2; io3Level = l3; txLow = tx[31:0]; txHigh = tx[63:32];
    expIo2 = l2; expIo3 = l3;
    rc = readyCnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R10", "busy after start", {63'b0, busy}, 64'd1);
    if (dup) begin
      repeat (20) @(negedge clk);
      opcode = 8'hFF; lenCode = 4'd9; txLow = ~tx[31:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (readyCnt == rc && !timedOut) @(negedge clk);
    repeat (3) @(negedge clk);

    check(readyCnt == rc + 1 && readyErr == r0, "R10", "ready pulse timing",
          64'(readyCnt - rc), 64'd1);
    check(nFrames == expFrames, "R11", "frame count", 64'(nFrames), 64'(expFrames));
    for (int i = 0; i < nPoll && i < 16; i++) begin
      check(fb[i][0] == 8'h05 && flen[i] == 2, "R8", "status poll frame",
            {fb[i][0], 32'(flen[i])}, {8'h05, 32'd2});
    end
    if (wr && nPoll < 16) begin
      check(fb[nPoll][0] == 8'h06 && flen[nPoll] == 1, "R7", "write-enable frame",
            {fb[nPoll][0], 32'(flen[nPoll])}, {8'h06, 32'd1});
    end
    mainIdx = expFrames - 1;
    if (mainIdx < 16) begin
      check(fb[mainIdx][0] == op, "R2", "command opcode", 64'(fb[mainIdx][0]), 64'(op));
      check(flen[mainIdx] == eff, "R5", "command length", 64'(flen[mainIdx]), 64'(eff));
      dataOk = 1'b1;
      for (int k = 0; k < eff - 1; k++) if (fb[mainIdx][k+1] != tx[k*8 +: 8]) dataOk = 1'b0;
      check(dataOk, "R3", "payload byte order", 64'(fb[mainIdx][1]), 64'(tx[7:0]));
    end
    expRx = tx;
    for (int k = 0; k < eff - 1; k++) expRx[k*8 +: 8] = mainResp(op, k + 1);
    check(rxLow == expRx[31:0], "R4", "rxLow", 64'(rxLow), 64'(expRx[31:0]));
    check(rxHigh == expRx[63:32], "R4", "rxHigh", 64'(rxHigh), 64'(expRx[63:32]));
    check(ioErr == i0, "R6", "io2/io3 levels in frame", 64'(ioErr - i0), 64'd0);
    check(gapErr == g0 && sckErr == s0 && partialErr == p0, "R9", "framing",
          64'(gapErr - g0 + sckErr - s0 + partialErr - p0), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(csN === 1'b1 && sck === 1'b0, "R1", "reset lines", {62'b0, csN, sck}, 64'd2);
    check(busy === 1'b0 && ready === 1'b0, "R1", "reset flags", {62'b0, busy, ready}, 64'd0);
    check(rxLow === 32'd0 && rxHigh === 32'd0, "R1", "reset rx", {rxHigh, rxLow}, 64'd0);
    check(io2 === 1'b1 && io3 === 1'b1, "R1", "reset io2/io3", {62'b0, io2, io3}, 64'd3);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int len = 0; len <= 10 && !timedOut; len++) begin
      for (int m = 0; m < 4 && !timedOut; m++) begin
        runTxn(8'(8'h40 + len * 5 + m),
               len,
               {32'h0123_4567 ^ 32'(len * 32'h1111),
                32'h89AB_CDEF ^ 32'(m * 32'h0F0F_0F0F) ^ 32'(len)},
               m[0], m[1], len % 3,
               len[0], m[0] ^ len[1],
               ((len + m) % 3) == 0);
      end
    end
    if (timedOut) check(1'b0, "R10", "watchdog expired", 64'(cyc), 64'd150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule